// File: doc/BRIEF.md
# Merging Dirty-Line Write Buffer

This block sits between a write-back cache and the next level of the memory hierarchy. It holds up to ten full lines on their way out: dirty lines that the cache evicted, and store data for stores that missed in the cache and were not allocated there. A write whose line address matches a buffered line is folded into that line's entry byte by byte instead of taking a new slot. Each entry keeps a valid bit for every byte, so partial writes can collect in one entry over time.

Entries go to the next level in the order they were allocated. They are offered only while the next level reports no read in progress. When every slot is occupied, the buffer offers its oldest entry even if a read is waiting. Once an entry has been offered, it is frozen: a later write to the same line opens a new entry. The cache looks up every miss in the buffer. The lookup port returns the buffered bytes for the requested line together with a byte mask, in the same cycle. If every byte is present, the miss can be filled from the buffer without using the next level. Otherwise the cache overlays the masked bytes on the line that comes back from the next level.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `drn_valid` is 0, `enq_ready` is 1 and `lk_hit` is 0 for any address.
- R2: An accepted write (`enq_valid` and `enq_ready` both 1 at a clock edge) with no mergeable match takes a new entry. From the next cycle a lookup of its address returns the written bytes, with `lk_mask` bit b set exactly for each set `enq_be` bit b. Byte b is data bits [8b+7:8b].
- R3: An accepted write whose address matches a buffered entry that is not being offered merges into that entry. The newly enabled bytes replace the old ones, and the entry's byte mask becomes the OR of both masks.
- R4: A write to the address of the entry currently offered on the drain port does not change that entry. It allocates a new entry instead.
- R5: Entries are offered in allocation order. `drn_addr`, `drn_data` and `drn_be` carry the oldest entry, with zero in data bytes that were never written. An entry leaves the buffer at the edge where `drn_valid` and `drn_ready` are both 1.
- R6: `drn_valid` rises one cycle after a cycle in which the buffer held at least one entry, no entry was being offered, and either `rd_pending` was 0 or all ten entries were occupied. Otherwise it does not rise.
- R7: While all entries are occupied, `enq_ready` is 0 unless the presented write would merge. A merging write is still accepted when the buffer is full.
- R8: Once `drn_valid` is 1, it stays 1 and the drain address, data and enables stay unchanged until the handshake, whatever `rd_pending` does.
- R9: `lk_hit` is 1 when any byte of the looked-up line is buffered. `lk_full` is 1 when all bytes are buffered. `lk_data` holds the buffered bytes and zero in bytes that are not buffered.
- R10: When two entries hold the same line, a lookup takes each byte from the youngest entry that has it.
- R11: Once an entry has drained, a lookup no longer returns its bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Write request |
| enq_ready | output | 1 | Write can be accepted this cycle |
| enq_addr | input | ADDR_W | Line address of the write |
| enq_data | input | 8*LINE_BYTES | Write data, byte b at bits [8b+7:8b] |
| enq_be | input | LINE_BYTES | Per-byte write enables |
| lk_addr | input | ADDR_W | Line address of a cache miss |
| lk_hit | output | 1 | Some byte of that line is buffered |
| lk_full | output | 1 | Every byte of that line is buffered |
| lk_data | output | 8*LINE_BYTES | Buffered bytes, zero elsewhere |
| lk_mask | output | LINE_BYTES | Which bytes `lk_data` supplies |
| rd_pending | input | 1 | Next level is busy with a read |
| drn_valid | output | 1 | Oldest entry offered to the next level |
| drn_ready | input | 1 | Next level takes the offered entry |
| drn_addr | output | ADDR_W | Line address of the offered entry |
| drn_data | output | 8*LINE_BYTES | Data of the offered entry |
| drn_be | output | LINE_BYTES | Valid bytes of the offered entry |

## Verification
The bench fills the buffer while reads are pending. A design that ignored the full condition would hold its entries forever, and one that ignored `rd_pending` would drain too early. It merges into a full buffer and checks that a design which back-pressured every write on a full count would refuse it. It writes to the line under offer: a design that merged there would change data already handed over and would break the hold rule. The two copies of that line are then looked up, which exposes a design that resolves them oldest-first. It also raises `rd_pending` during an offer to catch a design that withdraws the offer.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic {DRN_IDLE = 1'b0, DRN_OFFER = 1'b1} drain_state_t;
endpackage

// File: rtl/mwb_cam.sv
module mwb_cam #(
  parameter int DEPTH  = 10,
  parameter int ADDR_W = 16
) (
  input  logic [DEPTH-1:0]             ent_vld,
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  input  logic [DEPTH-1:0]             excl,
  input  logic [ADDR_W-1:0]            enq_addr,
  input  logic [ADDR_W-1:0]            lk_addr,
  output logic [DEPTH-1:0]             merge_vec,
  output logic [DEPTH-1:0]             lk_vec
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign merge_vec[g] = ent_vld[g] & ~excl[g] & (ent_addr[g] == enq_addr);
    assign lk_vec[g]    = ent_vld[g] & (ent_addr[g] == lk_addr);
  end
endmodule

// File: rtl/mwb_ctrl.sv
module mwb_ctrl import mwb_pkg::*; #(
  parameter int DEPTH = 10,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             pop,
  input  logic             rd_pending,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] occ,
  output drain_state_t     drn_state
);
  logic [IDX_W-1:0] head_d, tail_d;
  logic [CNT_W-1:0] occ_d;
  drain_state_t     state_d;
  logic             occ_full, start_ok;

  assign occ_full = (occ == CNT_W'(DEPTH));
  assign start_ok = (occ != '0) && (!rd_pending || occ_full);

  always_comb begin
    head_d  = head;
    tail_d  = tail;
    if (pop)   head_d = (head == IDX_W'(DEPTH - 1)) ? '0 : head + 1'b1;
    if (alloc) tail_d = (tail == IDX_W'(DEPTH - 1)) ? '0 : tail + 1'b1;
    occ_d   = occ + CNT_W'(alloc) - CNT_W'(pop);
    state_d = drn_state;
    case (drn_state)
      DRN_IDLE:  if (start_ok) state_d = DRN_OFFER;
      DRN_OFFER: if (pop)      state_d = DRN_IDLE;
      default:                 state_d = DRN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head      <= '0;
      tail      <= '0;
      occ       <= '0;
      drn_state <= DRN_IDLE;
    end else begin
      if (pop)         head <= head_d;
      if (alloc)       tail <= tail_d;
      if (alloc ^ pop) occ  <= occ_d;
      drn_state <= state_d;
    end
  end
endmodule

// File: rtl/mwb_overlay.sv
module mwb_overlay import mwb_pkg::*; #(
  parameter int DEPTH      = 10,
  parameter int LINE_BYTES = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]                        head,
  input  logic [DEPTH-1:0]                        lk_vec,
  input  byte_t [DEPTH-1:0][LINE_BYTES-1:0]       ent_data,
  input  logic [DEPTH-1:0][LINE_BYTES-1:0]        ent_be,
  output byte_t [LINE_BYTES-1:0]                  lk_data,
  output logic [LINE_BYTES-1:0]                   lk_mask
);
  // Walk from oldest to youngest so younger bytes overwrite older ones.
  always_comb begin
    logic [IDX_W:0] slot;
    lk_data = '0;
    lk_mask = '0;
    for (int a = 0; a < DEPTH; a++) begin
      slot = {1'b0, head} + (IDX_W + 1)'(a);
      if (slot >= (IDX_W + 1)'(DEPTH)) slot = slot - (IDX_W + 1)'(DEPTH);
      if (lk_vec[slot[IDX_W-1:0]]) begin
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (ent_be[slot[IDX_W-1:0]][b]) begin
            lk_data[b] = ent_data[slot[IDX_W-1:0]][b];
            lk_mask[b] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf import mwb_pkg::*; #(
  parameter int DEPTH      = 10,
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enq_valid,
  output logic                    enq_ready,
  input  logic [ADDR_W-1:0]       enq_addr,
  input  logic [8*LINE_BYTES-1:0] enq_data,
  input  logic [LINE_BYTES-1:0]   enq_be,
  input  logic [ADDR_W-1:0]       lk_addr,
  output logic                    lk_hit,
  output logic                    lk_full,
  output logic [8*LINE_BYTES-1:0] lk_data,
  output logic [LINE_BYTES-1:0]   lk_mask,
  input  logic                    rd_pending,
  output logic                    drn_valid,
  input  logic                    drn_ready,
  output logic [ADDR_W-1:0]       drn_addr,
  output logic [8*LINE_BYTES-1:0] drn_data,
  output logic [LINE_BYTES-1:0]   drn_be
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]                  vld_q, vld_d;
  logic [DEPTH-1:0][ADDR_W-1:0]      addr_q, addr_d;
  byte_t [DEPTH-1:0][LINE_BYTES-1:0] data_q, data_d;
  logic [DEPTH-1:0][LINE_BYTES-1:0]  be_q, be_d;

  logic [IDX_W-1:0] head, tail, merge_idx, tgt;
  logic [CNT_W-1:0] occ;
  drain_state_t     drn_state;
  logic [DEPTH-1:0] merge_vec, lk_vec, excl;
  logic             merge_hit, enq_fire, alloc, pop;
  byte_t [LINE_BYTES-1:0] lk_bytes;

  assign merge_hit = |merge_vec;
  assign enq_ready = (occ != CNT_W'(DEPTH)) | merge_hit;
  assign enq_fire  = enq_valid & enq_ready;
  assign alloc     = enq_fire & ~merge_hit;
  assign drn_valid = (drn_state == DRN_OFFER);
  assign pop       = drn_valid & drn_ready;

  always_comb begin
    merge_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (merge_vec[i]) merge_idx = IDX_W'(i);
    excl = '0;
    if (drn_valid) excl[head] = 1'b1;
  end

  mwb_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cam (
    .ent_vld(vld_q), .ent_addr(addr_q), .excl(excl),
    .enq_addr(enq_addr), .lk_addr(lk_addr),
    .merge_vec(merge_vec), .lk_vec(lk_vec)
  );

  mwb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .pop(pop),
    .rd_pending(rd_pending), .head(head), .tail(tail),
    .occ(occ), .drn_state(drn_state)
  );

  mwb_overlay #(.DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES)) u_overlay (
    .head(head), .lk_vec(lk_vec), .ent_data(data_q), .ent_be(be_q),
    .lk_data(lk_bytes), .lk_mask(lk_mask)
  );

  assign lk_data = lk_bytes;
  assign lk_hit  = |lk_mask;
  assign lk_full = &lk_mask;

  assign drn_addr = addr_q[head];
  assign drn_data = data_q[head];
  assign drn_be   = be_q[head];

  // Next state of the entry storage.
  always_comb begin
    vld_d  = vld_q;
    addr_d = addr_q;
    data_d = data_q;
    be_d   = be_q;
    tgt    = merge_hit ? merge_idx : tail;
    if (pop) vld_d[head] = 1'b0;
    if (enq_fire) begin
      if (!merge_hit) begin
        vld_d[tgt]  = 1'b1;
        addr_d[tgt] = enq_addr;
        data_d[tgt] = '0;
        be_d[tgt]   = '0;
      end
      for (int b = 0; b < LINE_BYTES; b++)
        if (enq_be[b]) data_d[tgt][b] = enq_data[8*b +: 8];
      be_d[tgt] = be_d[tgt] | enq_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                vld_q <= '0;
    else if (enq_fire | pop)   vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (enq_fire) begin
      addr_q <= addr_d;
      data_q <= data_d;
      be_q   <= be_d;
    end
  end
endmodule

// File: rtl/mwb_checker.sv
module mwb_checker #(
  parameter int DEPTH      = 10,
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    enq_ready,
  input logic                    rd_pending,
  input logic                    drn_valid,
  input logic                    drn_ready,
  input logic [ADDR_W-1:0]       drn_addr,
  input logic [8*LINE_BYTES-1:0] drn_data,
  input logic [LINE_BYTES-1:0]   drn_be,
  input logic                    lk_hit,
  input logic                    lk_full,
  input logic [CNT_W-1:0]        occ,
  input logic [DEPTH-1:0]        merge_vec
);
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    drn_valid && !drn_ready |=> drn_valid && $stable(drn_addr) && $stable(drn_data) && $stable(drn_be)); // R8
  AST_NO_START_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drn_valid) |-> (!$past(rd_pending) || $past(occ) == CNT_W'(DEPTH))); // R6
  AST_FULL_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH) && merge_vec == '0) |-> !enq_ready); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH)); // R7
  AST_SINGLE_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(merge_vec)); // R3
  AST_LOOKUP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    lk_full |-> lk_hit); // R9
endmodule

bind merge_wbuf mwb_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) i_chk (
  .clk(clk), .rst_n(rst_n), .enq_ready(enq_ready), .rd_pending(rd_pending),
  .drn_valid(drn_valid), .drn_ready(drn_ready), .drn_addr(drn_addr),
  .drn_data(drn_data), .drn_be(drn_be), .lk_hit(lk_hit), .lk_full(lk_full),
  .occ(occ), .merge_vec(merge_vec)
);

// File: tb/test_merge_wbuf.sv
module test_merge_wbuf;
  localparam int DEPTH = 10;
  localparam int AW    = 16;
  localparam int NB    = 8;

  logic clk, rst_n;
  logic enq_valid, enq_ready;
  logic [AW-1:0] enq_addr, lk_addr, drn_addr;
  logic [8*NB-1:0] enq_data, lk_data, drn_data;
  logic [NB-1:0] enq_be, lk_mask, drn_be;
  logic lk_hit, lk_full, rd_pending, drn_valid, drn_ready;

  merge_wbuf #(.DEPTH(DEPTH), .ADDR_W(AW), .LINE_BYTES(NB)) i_merge_wbuf (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_addr(enq_addr), .enq_data(enq_data), .enq_be(enq_be),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_full(lk_full), .lk_data(lk_data),
    .lk_mask(lk_mask), .rd_pending(rd_pending), .drn_valid(drn_valid),
    .drn_ready(drn_ready), .drn_addr(drn_addr), .drn_data(drn_data), .drn_be(drn_be)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct { logic [AW-1:0] addr; logic [8*NB-1:0] data; logic [NB-1:0] be; } ent_t;
  ent_t sb[$];          // scoreboard: expected entries, oldest first
  bit   exp_offer;
  int   n_chk, n_fail;
  bit   done;

  task automatic chk(string req, logic [8*NB-1:0] act, logic [8*NB-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [8*NB-1:0] bmask(logic [NB-1:0] be);
    logic [8*NB-1:0] m = '0;
    for (int b = 0; b < NB; b++) if (be[b]) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  // One cycle: drive at negedge, compare outputs, advance the scoreboard for the edge.
  task automatic cyc(bit ev, logic [AW-1:0] ea, logic [8*NB-1:0] ed, logic [NB-1:0] eb,
                     bit rdp, bit drdy, logic [AW-1:0] la, string tag);
    logic [8*NB-1:0] xd;
    logic [NB-1:0]   xm;
    int tgt;
    int pre;
    bit xready, pop, fire;
    enq_valid = ev; enq_addr = ea; enq_data = ed; enq_be = eb;
    rd_pending = rdp; drn_ready = drdy; lk_addr = la;
    #1;
    tgt = -1;
    foreach (sb[i]) if (sb[i].addr == ea && !(i == 0 && exp_offer)) tgt = i;
    pre = sb.size();
    xready = (pre < DEPTH) || (tgt >= 0);
    xd = '0; xm = '0;
    foreach (sb[i]) if (sb[i].addr == la) begin
      xd = (xd & ~bmask(sb[i].be)) | (sb[i].data & bmask(sb[i].be));
      xm = xm | sb[i].be;
    end
    chk("R7 enq_ready", 64'(enq_ready), 64'(xready));
    chk("R6 drn_valid", 64'(drn_valid), 64'(exp_offer));
    if (exp_offer) begin
      chk({tag, " drn_addr"}, 64'(drn_addr), 64'(sb[0].addr));
      chk({tag, " drn_data"}, drn_data, sb[0].data);
      chk({tag, " drn_be"}, 64'(drn_be), 64'(sb[0].be));
    end
    chk({tag, " lk_mask"}, 64'(lk_mask), 64'(xm));
    chk({tag, " lk_data"}, lk_data, xd);
    chk({tag, " lk_hit/full"}, 64'({lk_hit, lk_full}), 64'({|xm, &xm}));
    pop  = exp_offer && drdy;
    fire = ev && xready;
    if (exp_offer) exp_offer = !pop;
    else           exp_offer = (pre != 0) && (!rdp || pre == DEPTH);
    if (pop) begin
      void'(sb.pop_front());
      if (tgt >= 0) tgt--;
    end
    if (fire) begin
      if (tgt >= 0) begin
        sb[tgt].data = (sb[tgt].data & ~bmask(eb)) | (ed & bmask(eb));
        sb[tgt].be   = sb[tgt].be | eb;
      end else begin
        ent_t e;
        e.addr = ea; e.data = ed & bmask(eb); e.be = eb;
        sb.push_back(e);
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(bit rdp, bit drdy, logic [AW-1:0] la, string tag);
    cyc(1'b0, '0, '0, '0, rdp, drdy, la, tag);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0; exp_offer = 0;
    rst_n = 1'b0;
    enq_valid = 0; enq_addr = '0; enq_data = '0; enq_be = '0;
    rd_pending = 1; drn_ready = 0; lk_addr = 16'h0010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 drn_valid", 64'(drn_valid), 64'd0);
    chk("R1 enq_ready", 64'(enq_ready), 64'd1);
    chk("R1 lk_hit", 64'(lk_hit), 64'd0);
    @(negedge clk);
    // R2: partial allocation
    cyc(1, 16'h0010, 64'h1111_2222_3333_4444, 8'h0F, 1, 0, 16'h0010, "R2");
    idle(1, 0, 16'h0010, "R2");
    // R3: merge upper half, then overwrite middle bytes
    cyc(1, 16'h0010, 64'h5555_6666_7777_8888, 8'hF0, 1, 0, 16'h0010, "R3");
    idle(1, 0, 16'h0010, "R3");
    cyc(1, 16'h0010, 64'hAAAA_BBBB_CCCC_DDDD, 8'h3C, 1, 0, 16'h0010, "R3");
    // R6: reads pending, nothing drains
    repeat (3) idle(1, 0, 16'h0010, "R6");
    // Fill to capacity with reads pending
    for (int i = 1; i < DEPTH; i++)
      cyc(1, 16'h0100 + 16'(i), {8{8'(i)}}, 8'hFF, 1, 0, 16'h0100 + 16'(i), "R2");
    idle(1, 0, 16'h0010, "R6");   // full: offer rises despite read
    // R7: new line refused, merge accepted while full
    cyc(1, 16'h0200, 64'hDEAD_BEEF_0000_0001, 8'hFF, 1, 0, 16'h0200, "R7");
    cyc(1, 16'h0101, 64'h0000_0000_0000_00EE, 8'h01, 1, 0, 16'h0101, "R7");
    idle(1, 0, 16'h0101, "R7");
    // Drain head with reads pending; then no restart (not full)
    cyc(0, '0, '0, '0, 1, 1, 16'h0010, "R5");
    repeat (3) idle(1, 1, 16'h0010, "R11");
    // Reads released: drain in allocation order
    repeat (24) idle(0, 1, 16'h0105, "R5");
    // R4/R10: write to line under offer opens a new entry
    cyc(1, 16'h0333, 64'h0102_0304_0506_0708, 8'hFF, 0, 0, 16'h0333, "R2");
    idle(0, 0, 16'h0333, "R8");
    cyc(1, 16'h0333, 64'hF1F2_F3F4_F5F6_F7F8, 8'h0F, 1, 0, 16'h0333, "R4");
    repeat (3) idle(1, 0, 16'h0333, "R10");
    // R8: offer held while read pending, then taken; R11: only younger bytes remain
    cyc(0, '0, '0, '0, 1, 1, 16'h0333, "R8");
    repeat (2) idle(0, 0, 16'h0333, "R11");
    // Merge into second entry allowed before it is offered? it is now offered: allocate
    cyc(1, 16'h0333, 64'h9900_0000_0000_0000, 8'h80, 0, 0, 16'h0333, "R4");
    repeat (8) idle(0, 1, 16'h0333, "R5");
    idle(0, 0, 16'h0333, "R11");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule